// File: doc/BRIEF.md
# Power-on Reset Time-out Sequencer

This block keeps a processor core in reset after power is applied, or after the core wakes from a low-power state, until its clock can be trusted. It runs up to three timed stages, one after another. The first is a power-up delay counted on the slow internal oscillator. The second is a start-up count of main-oscillator cycles, which gives a crystal or resonator time to settle. The third is a lock delay for the frequency-multiplying PLL.

The oscillator-mode code selects which stages run. So do an active-low power-up-timer enable and the cause of the sequence (power-on or wake). The stage controller runs on the internal oscillator. The start-up counter runs on the main oscillator, and its handshake crosses between the two clock domains through two-flop synchronisers. The external master-clear pin only gates the reset output. It never restarts a timer. If the pin is held low until every stage has expired, the core runs as soon as the pin is released.

Top module: `por_timeout_seq`

## Requirements
- R1: With `pwrtEnN` = 0, a power-on sequence first spends 2**PwrtBits `intClk` ticks in the power-up stage before any later stage begins.
- R2: With `pwrtEnN` = 1, the power-up stage is skipped entirely.
- R3: For mode codes 0 (low-power crystal), 1 (crystal), 2 (fast crystal) and 3 (fast crystal with PLL), a start-up stage of OstCycles `oscClk` cycles runs after the power-up stage.
- R4: For mode codes 4 (external clock), 5 (RC), 6 (internal oscillator) and the unused code 7, the start-up stage is skipped.
- R5: Only for mode code 3, a PLL-lock stage of PllTicks `intClk` ticks follows the start-up stage.
- R6: The wake input has the following effects. A one-cycle `wakeReq` while the core runs asserts `coreReset` and re-runs the start-up stage (and, for code 3, the lock stage) without the power-up stage. In modes without a start-up stage, `wakeReq` has no effect. While a sequence is still in progress, `wakeReq` is ignored.
- R7: In RC mode (code 5) with `pwrtEnN` = 1 there is no time-out: `coreReset` falls within three `intClk` cycles of POR release.
- R8: While `mclrN` is low, `coreReset` is high. Releasing `mclrN` after all stages have expired drops `coreReset` at once, without a clock edge and without re-running any stage.
- R9: `porPulse` high asserts `coreReset` at once and restarts the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intClk | input | 1 | Slow internal oscillator; clocks the stage controller, the power-up counter and the lock counter |
| oscClk | input | 1 | Main oscillator; clocks the start-up counter |
| porPulse | input | 1 | Power-on reset pulse, active high, asynchronous |
| mclrN | input | 1 | External master clear, active low |
| wakeReq | input | 1 | One-cycle request (synchronous to `intClk`) to leave a low-power state |
| oscMode | input | 3 | Oscillator mode code (see R3, R4) |
| pwrtEnN | input | 1 | Power-up timer enable, active low |
| coreReset | output | 1 | Reset to the core, active high |

## Verification
Power-on sequences are run for every mode code, with the power-up timer both enabled and disabled. The release time of each run tells apart the five stage combinations: none, power-up only, start-up only, power-up plus start-up, and all three. The stage lengths are chosen so that no two combinations fall within the timing tolerance of each other. Wake pulses are given in a crystal mode, in the PLL mode, in RC mode and in the middle of a running sequence. These runs separate a correct restart from a restart that wrongly includes the power-up stage and from a wake that is wrongly acted on. Master clear is held low across a whole sequence and then released, and it is also pulsed while the core runs. These runs distinguish pure gating of the output from a pin that restarts the timers.

// File: rtl/porseq_pkg.sv
`timescale 1ns/1ps
package porseq_pkg;

  typedef enum logic [2:0] {
    OSC_LOWPWR_XTAL  = 3'd0,
    OSC_XTAL         = 3'd1,
    OSC_FAST_XTAL    = 3'd2,
    OSC_FAST_XTALPLL = 3'd3,
    OSC_EXT_CLK      = 3'd4,
    OSC_RC           = 3'd5,
    OSC_INTERNAL     = 3'd6,
    OSC_SPARE        = 3'd7
  } oscMode_e;

  typedef enum logic [4:0] {
    ST_IDLE    = 5'b00001,
    ST_POWERUP = 5'b00010,
    ST_OSCWAIT = 5'b00100,
    ST_PLLWAIT = 5'b01000,
    ST_RUN     = 5'b10000
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic powerupRun;
    logic oscRun;
    logic pllRun;
  } stageStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic powerupDone;
    logic oscDone;
    logic pllDone;
  } stageDone_t;

  function automatic logic needsOscWait(input logic [2:0] mode);
    return (mode <= 3'(OSC_FAST_XTALPLL));
  endfunction

  function automatic logic needsPllWait(input logic [2:0] mode);
    return (mode == 3'(OSC_FAST_XTALPLL));
  endfunction

endpackage

// File: rtl/porseq_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser; with d tied high it doubles as a reset synchroniser
module porseq_sync #(
  parameter int Width = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] d,
  output logic [Width-1:0] q
);
  logic [Width-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/porseq_counter.sv
`timescale 1ns/1ps
// Counts while run is high, holds at Limit, clears when run drops
module porseq_counter #(
  parameter int Limit = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic done
);
  localparam int CntW = $clog2(Limit + 1);
  localparam logic [CntW-1:0] LimitV = CntW'(Limit);

  logic [CntW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (cnt != LimitV)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LimitV);
endmodule

// File: rtl/porseq_datapath.sv
`timescale 1ns/1ps
module porseq_datapath
  import porseq_pkg::*;
#(
  parameter int PwrtBits  = 11,
  parameter int OstCycles = 1024,
  parameter int PllTicks  = 63
) (
  input  logic         intClk,
  input  logic         intRstN,
  input  logic         oscClk,
  input  logic         oscRstN,
  input  stageStrobe_t strobe,
  output stageDone_t   done
);
  localparam int PwrtTicks = 1 << PwrtBits;

  logic oscRunSync, oscDoneRaw, oscDoneSync, oscArmed;

  porseq_counter #(.Limit(PwrtTicks)) u_powerupCnt (
    .clk(intClk), .rstN(intRstN), .run(strobe.powerupRun), .done(done.powerupDone)
  );

  porseq_counter #(.Limit(PllTicks)) u_pllCnt (
    .clk(intClk), .rstN(intRstN), .run(strobe.pllRun), .done(done.pllDone)
  );

  // start request crosses into the main-oscillator domain
  porseq_sync #(.Width(1)) u_runSync (
    .clk(oscClk), .rstN(oscRstN), .d(strobe.oscRun), .q(oscRunSync)
  );

  porseq_counter #(.Limit(OstCycles)) u_oscCnt (
    .clk(oscClk), .rstN(oscRstN), .run(oscRunSync), .done(oscDoneRaw)
  );

  // completion crosses back into the internal-oscillator domain
  porseq_sync #(.Width(1)) u_doneSync (
    .clk(intClk), .rstN(intRstN), .d(oscDoneRaw), .q(oscDoneSync)
  );

  // a stale done from an earlier run must be seen low before it counts
  always_ff @(posedge intClk or negedge intRstN) begin
    if (!intRstN)           oscArmed <= 1'b0;
    else if (!strobe.oscRun) oscArmed <= 1'b0;
    else if (!oscDoneSync)  oscArmed <= 1'b1;
  end

  assign done.oscDone = strobe.oscRun && oscArmed && oscDoneSync;
endmodule

// File: rtl/porseq_ctrl.sv
`timescale 1ns/1ps
module porseq_ctrl
  import porseq_pkg::*;
#(
  parameter int PwrtBits = 11,
  parameter int PllTicks = 63
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   oscMode,
  input  logic         pwrtEnN,
  input  logic         wakeReq,
  input  stageDone_t   done,
  output stageStrobe_t strobe,
  output logic         inRun
);
  localparam int PwrtTicks = 1 << PwrtBits;
  localparam int DwellMax  = (PwrtTicks > PllTicks) ? PwrtTicks : PllTicks;
  localparam int DwellW    = $clog2(DwellMax + 2);

  seqState_e state, nextState;
  logic      hasOsc, hasPll;

  assign hasOsc = needsOscWait(oscMode);
  assign hasPll = needsPllWait(oscMode);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (!pwrtEnN)    nextState = ST_POWERUP;
        else if (hasOsc) nextState = ST_OSCWAIT;
        else             nextState = ST_RUN;
      end
      ST_POWERUP: if (done.powerupDone) nextState = hasOsc ? ST_OSCWAIT : ST_RUN;
      ST_OSCWAIT: if (done.oscDone)     nextState = hasPll ? ST_PLLWAIT : ST_RUN;
      ST_PLLWAIT: if (done.pllDone)     nextState = ST_RUN;
      ST_RUN:     if (wakeReq && hasOsc) nextState = ST_OSCWAIT;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.powerupRun = (state == ST_POWERUP);
  assign strobe.oscRun     = (state == ST_OSCWAIT);
  assign strobe.pllRun     = (state == ST_PLLWAIT);
  assign inRun             = (state == ST_RUN);

  // ---------------- checks ----------------
  logic [DwellW-1:0] dwell;
  logic inIdle, inPwrt, inOst, inPll;

  assign inIdle = (state == ST_IDLE);
  assign inPwrt = (state == ST_POWERUP);
  assign inOst  = (state == ST_OSCWAIT);
  assign inPll  = (state == ST_PLLWAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    dwell <= '0;
    else if (nextState != state)  dwell <= '0;
    else if (dwell != '1)         dwell <= dwell + 1'b1;
  end

  assert_pwrt_length_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!inPwrt && $past(inPwrt)) |-> ($past(dwell) >= DwellW'(PwrtTicks)));

  assert_pwrt_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && pwrtEnN) |=> !inPwrt);

  assert_pll_after_ost_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inPll && !$past(inPll)) |-> $past(inOst));

  assert_pll_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!inPll && $past(inPll)) |-> ($past(dwell) >= DwellW'(PllTicks)));

  assert_wake_no_pwrt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inRun && wakeReq) |=> !inPwrt);
endmodule

// File: rtl/por_timeout_seq.sv
`timescale 1ns/1ps
module por_timeout_seq
  import porseq_pkg::*;
#(
  parameter int PwrtBits  = 11,
  parameter int OstCycles = 1024,
  parameter int PllTicks  = 63
) (
  input  logic       intClk,
  input  logic       oscClk,
  input  logic       porPulse,
  input  logic       mclrN,
  input  logic       wakeReq,
  input  logic [2:0] oscMode,
  input  logic       pwrtEnN,
  output logic       coreReset
);
  logic         intRstN, oscRstN, inRun;
  stageStrobe_t strobe;
  stageDone_t   done;

  // asynchronous assertion, synchronous release in each domain
  porseq_sync #(.Width(1)) u_intRstSync (
    .clk(intClk), .rstN(!porPulse), .d(1'b1), .q(intRstN)
  );
  porseq_sync #(.Width(1)) u_oscRstSync (
    .clk(oscClk), .rstN(!porPulse), .d(1'b1), .q(oscRstN)
  );

  porseq_ctrl #(.PwrtBits(PwrtBits), .PllTicks(PllTicks)) u_ctrl (
    .clk(intClk), .rstN(intRstN), .oscMode(oscMode), .pwrtEnN(pwrtEnN),
    .wakeReq(wakeReq), .done(done), .strobe(strobe), .inRun(inRun)
  );

  porseq_datapath #(.PwrtBits(PwrtBits), .OstCycles(OstCycles), .PllTicks(PllTicks)) u_dp (
    .intClk(intClk), .intRstN(intRstN), .oscClk(oscClk), .oscRstN(oscRstN),
    .strobe(strobe), .done(done)
  );

  assign coreReset = !inRun || !mclrN;
endmodule

// File: tb/por_timeout_seq_tb.sv
`timescale 1ns/1ps
module por_timeout_seq_tb;
  localparam int PwrtBits  = 5;
  localparam int OstCycles = 40;
  localparam int PllTicks  = 20;
  localparam int IntNs = 4;   // 250 MHz
  localparam int OscNs = 6;
  localparam int Slack = 5;

  logic intClk = 1'b0, oscClk = 1'b0;
  logic porPulse = 1'b1, mclrN = 1'b1, wakeReq = 1'b0, pwrtEnN = 1'b1;
  logic [2:0] oscMode = 3'd0;
  logic coreReset;

  int total = 0, failed = 0;
  bit finished = 1'b0;

  always #(IntNs/2) intClk = ~intClk;
  always #(OscNs/2) oscClk = ~oscClk;

  por_timeout_seq #(.PwrtBits(PwrtBits), .OstCycles(OstCycles), .PllTicks(PllTicks)) u_dut (
    .intClk(intClk), .oscClk(oscClk), .porPulse(porPulse), .mclrN(mclrN),
    .wakeReq(wakeReq), .oscMode(oscMode), .pwrtEnN(pwrtEnN), .coreReset(coreReset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected release cycle, counted from POR release (or from the wake edge)
  function automatic int nominal(input int mode, input bit enN, input bit fromWake);
    int e = fromWake ? 1 : 3;
    if (!fromWake && !enN) e += (1 << PwrtBits) + 1;
    if (mode <= 3) e += (OstCycles * OscNs + IntNs - 1) / IntNs + 6;
    if (mode == 3) e += PllTicks + 1;
    return e;
  endfunction

  task automatic startPor(input int mode, input bit enN);
    @(negedge intClk);
    porPulse = 1'b1;
    oscMode  = 3'(mode);
    pwrtEnN  = enN;
    repeat (3) begin
      @(negedge intClk);
      chk(coreReset == 1'b1, "R9 reset held while POR high", coreReset, 1);
    end
    porPulse = 1'b0;
  endtask

  // per-cycle comparison against the timing window of the model
  task automatic watchRelease(input int nom, input string req, input int wakeAt);
    int lo = nom - Slack;
    int hi = nom + Slack;
    int rel = -1;
    for (int el = 1; el <= hi + 20 && rel < 0; el++) begin
      @(posedge intClk);
      @(negedge intClk);
      wakeReq = 1'b0;
      if (el < lo) chk(coreReset == 1'b1, {req, " held early"}, coreReset, 1);
      if (!mclrN)  chk(coreReset == 1'b1, "R8 mclr low holds reset", coreReset, 1);
      if (coreReset == 1'b0) rel = el;
      if (el == wakeAt) wakeReq = 1'b1;
    end
    chk(rel >= lo && rel <= hi, {req, " release cycle"}, rel, nom);
    repeat (10) begin
      @(negedge intClk);
      chk(coreReset == 1'b0, {req, " stays released"}, coreReset, 0);
    end
  endtask

  task automatic wakeExpect(input int mode);
    @(negedge intClk);
    wakeReq = 1'b1;
    watchRelease(nominal(mode, 1'b1, 1'b1), "R6 wake restart", -1);
  endtask

  task automatic wakeIgnored(input string req);
    @(negedge intClk);
    wakeReq = 1'b1;
    repeat (100) begin
      @(negedge intClk);
      wakeReq = 1'b0;
      chk(coreReset == 1'b0, req, coreReset, 0);
    end
  endtask

  initial begin
    #1;
    chk(coreReset == 1'b1, "R9 reset state", coreReset, 1);

    startPor(4, 1'b0); watchRelease(nominal(4, 1'b0, 1'b0), "R1 power-up only", -1);
    startPor(2, 1'b0); watchRelease(nominal(2, 1'b0, 1'b0), "R3 power-up then start-up", -1);
    startPor(3, 1'b0); watchRelease(nominal(3, 1'b0, 1'b0), "R5 all three stages", -1);
    startPor(6, 1'b1); watchRelease(nominal(6, 1'b1, 1'b0), "R2 R4 internal osc no timer", -1);
    startPor(7, 1'b0); watchRelease(nominal(7, 1'b0, 1'b0), "R4 spare code like ext clock", -1);
    startPor(0, 1'b1); watchRelease(nominal(0, 1'b1, 1'b0), "R3 start-up only", -1);
    startPor(5, 1'b1); watchRelease(nominal(5, 1'b1, 1'b0), "R7 RC no time-out", -1);
    wakeIgnored("R6 wake ignored in RC mode");

    startPor(1, 1'b0); watchRelease(nominal(1, 1'b0, 1'b0), "R6 wake mid-sequence ignored", 10);
    wakeExpect(1);
    startPor(3, 1'b0); watchRelease(nominal(3, 1'b0, 1'b0), "R5 PLL mode power-on", -1);
    wakeExpect(3);

    // master clear held across the whole sequence
    @(negedge intClk); mclrN = 1'b0;
    startPor(3, 1'b0);
    repeat (200) begin
      @(negedge intClk);
      chk(coreReset == 1'b1, "R8 mclr low holds reset", coreReset, 1);
    end
    mclrN = 1'b1;
    #1 chk(coreReset == 1'b0, "R8 immediate release after expiry", coreReset, 0);

    // master clear pulsed while running: gates only, no timers re-run
    @(negedge intClk); mclrN = 1'b0;
    #1 chk(coreReset == 1'b1, "R8 mclr asserts reset", coreReset, 1);
    @(negedge intClk); mclrN = 1'b1;
    #1 chk(coreReset == 1'b0, "R8 no restart after mclr", coreReset, 0);
    repeat (20) begin
      @(negedge intClk);
      chk(coreReset == 1'b0, "R8 no restart after mclr", coreReset, 0);
    end

    // POR while running
    @(negedge intClk); porPulse = 1'b1;
    #1 chk(coreReset == 1'b1, "R9 POR asserts at once", coreReset, 1);
    @(negedge intClk); porPulse = 1'b0;
    watchRelease(nominal(3, 1'b0, 1'b0), "R9 full restart", -1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(IntNs * 100000);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule